// File: doc/BRIEF.md
# Supply Reset Sequencer

This block turns two digitised supply-monitor flags and a manual reset request into an active-low system reset. One flag reports that the supply is at or below the lower trip level. The other reports that the supply is at or above the upper trip level. Reset asserts on the lower flag. It is released only after the upper flag has been seen and a full release delay has run out, so the gap between the two trip levels acts as hysteresis. A high level on the manual request, once it has lasted a minimum width, also forces reset. Removing that request starts the same full delay.

The release delay is counted in clock cycles derived from the `CLK_HZ` parameter. `dly_sel` picks one of three delays: `DLY_A_MS`, `DLY_B_MS` and `DLY_C_MS` (50, 100 and 200 ms by default). The selection is captured when counting begins. The reset is presented twice. `rst_out_n` is a plain active-low reset. `pad_pull_en` enables an open-drain pull-down and is high exactly while reset is asserted; the block never drives the line high.

The controller has four states:
- **ST_UNDERV**: supply low or not yet confirmed. This is the state after the logic reset.
- **ST_MANUAL**: a qualified manual request is being held.
- **ST_DELAY**: the release delay is counting.
- **ST_RUN**: reset is released.

The transitions, checked in priority order, are:
- From any state, `uv_low` goes to ST_UNDERV.
- From any state, a qualified manual request goes to ST_MANUAL.
- ST_UNDERV goes to ST_DELAY on `ov_high`.
- ST_MANUAL goes to ST_DELAY when the request ends, if the supply is confirmed; otherwise it goes to ST_UNDERV.
- ST_DELAY goes to ST_RUN when the count completes.
- ST_RUN stays in ST_RUN.

Top module: `supply_reset_seq`

## Requirements
- R1: While `rst_n` is low, and after it rises, `rst_out_n` is 0 and `pad_pull_en` is 1. Release then still needs `ov_high` followed by a full delay.
- R2: `uv_low` high at a clock edge makes `rst_out_n` 0 from that edge on, from any state.
- R3: After an undervoltage, reset stays asserted while `ov_high` is 0. Once released, `uv_low`=0 together with `ov_high`=0 keeps reset released (hysteresis).
- R4: Release happens exactly N cycles after ST_DELAY is entered. N is `CLK_HZ/1000*DLY_A_MS` for `dly_sel`=00, `*DLY_B_MS` for 01, and `*DLY_C_MS` for both 10 and 11.
- R5: Changing `dly_sel` while the delay is counting has no effect on the release time.
- R6: `mr_req` held high for at least Q synchronised cycles forces reset. Q is `ceil(CLK_HZ*MR_MIN_US/1e6)`, which is 2 when `CLK_HZ` is 100000.
- R7: A `mr_req` pulse shorter than Q cycles is ignored: reset stays released.
- R8: Removing a qualified manual request starts a full delay. A new request during the delay discards the partial count.
- R9: `uv_low` during the delay clears the count. A fresh full delay follows the next `ov_high`.
- R10: `pad_pull_en` is always the inverse of `rst_out_n`.
- R11: When `uv_low` and `ov_high` are both 1, `uv_low` wins and reset stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| uv_low | input | 1 | Supply at or below the lower trip level |
| ov_high | input | 1 | Supply at or above the upper trip level |
| mr_req | input | 1 | Asynchronous active-high manual reset request |
| dly_sel | input | 2 | Release delay choice (00, 01, 10/11) |
| rst_out_n | output | 1 | Active-low system reset |
| pad_pull_en | output | 1 | Open-drain pull-down enable, high while reset is asserted |

## Verification
The assertions assume `uv_low` and `ov_high` are already synchronous to `clk` and are never both meaningful-high in a way the comparators cannot produce, apart from the overlap case R11 resolves. They also assume `mr_req` is the only asynchronous input. The stimulus changes every input on the falling clock edge and holds each value for whole cycles. It drives the flags as clean levels with no glitches between edges, and makes manual pulses an exact number of cycles long, so that the Q-cycle boundary is exercised precisely.

// File: rtl/srs_pkg.sv
package srs_pkg;
    typedef enum logic [1:0] {
        ST_UNDERV = 2'd0,
        ST_MANUAL = 2'd1,
        ST_DELAY  = 2'd2,
        ST_RUN    = 2'd3
    } seq_state_t;
endpackage

// File: rtl/srs_mr_filter.sv
// Synchronises the manual request and qualifies it by width.
module srs_mr_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYC    = 2,
    localparam int QW         = $clog2(QUAL_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mr_async,
    output logic mr_hold
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [QW-1:0]          width_q;
    logic                   mr_s;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= mr_async;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    assign mr_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       width_q <= '0;
        else if (!mr_s)                   width_q <= '0;
        else if (width_q != QW'(QUAL_CYC)) width_q <= width_q + QW'(1);
    end

    assign mr_hold = (width_q == QW'(QUAL_CYC));
endmodule

// File: rtl/srs_release_timer.sv
// Counts the release delay; the limit is captured while idle.
module srs_release_timer #(
    parameter int CW    = 24,
    parameter int LIM_A = 5000,
    parameter int LIM_B = 10000,
    parameter int LIM_C = 20000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [1:0]    sel,
    output logic          done
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_q;
    logic [CW-1:0] lim_pick;

    always_comb begin
        unique case (sel)
            2'b00:   lim_pick = CW'(LIM_A);
            2'b01:   lim_pick = CW'(LIM_B);
            default: lim_pick = CW'(LIM_C);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= CW'(LIM_C);
        end else if (!run) begin
            cnt_q <= '0;
            lim_q <= lim_pick;
        end else if (cnt_q != lim_q - CW'(1)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign done = run && (cnt_q == lim_q - CW'(1));
endmodule

// File: rtl/srs_seq_fsm.sv
// Reset sequencing state machine.
module srs_seq_fsm
    import srs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic uv_low,
    input  logic ov_high,
    input  logic mr_hold,
    input  logic tmr_done,
    output logic tmr_run,
    output logic rst_out_n,
    output logic pad_pull_en
);
    seq_state_t st_q, st_nxt;
    logic       sup_ok_q;

    // Supply confirmed: set by upper flag, cleared by lower flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sup_ok_q <= 1'b0;
        else if (uv_low)  sup_ok_q <= 1'b0;
        else if (ov_high) sup_ok_q <= 1'b1;
    end

    always_comb begin
        st_nxt = st_q;
        if (uv_low) begin
            st_nxt = ST_UNDERV;
        end else if (mr_hold) begin
            st_nxt = ST_MANUAL;
        end else begin
            unique case (st_q)
                ST_UNDERV: if (ov_high) st_nxt = ST_DELAY;
                ST_MANUAL: st_nxt = (sup_ok_q || ov_high) ? ST_DELAY : ST_UNDERV;
                ST_DELAY:  if (tmr_done) st_nxt = ST_RUN;
                ST_RUN:    st_nxt = ST_RUN;
                default:   st_nxt = ST_UNDERV;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_UNDERV;
        else        st_q <= st_nxt;
    end

    always_comb begin
        tmr_run     = (st_q == ST_DELAY);
        rst_out_n   = (st_q == ST_RUN);
        pad_pull_en = (st_q != ST_RUN);
    end
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int DLY_A_MS    = 50,
    parameter int DLY_B_MS    = 100,
    parameter int DLY_C_MS    = 200,
    parameter int MR_MIN_US   = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uv_low,
    input  logic       ov_high,
    input  logic       mr_req,
    input  logic [1:0] dly_sel,
    output logic       rst_out_n,
    output logic       pad_pull_en
);
    localparam int CYC_PER_MS = CLK_HZ / 1000;
    localparam int LIM_A      = CYC_PER_MS * DLY_A_MS;
    localparam int LIM_B      = CYC_PER_MS * DLY_B_MS;
    localparam int LIM_C      = CYC_PER_MS * DLY_C_MS;
    localparam int LIM_AB     = (LIM_A > LIM_B) ? LIM_A : LIM_B;
    localparam int LIM_MAX    = (LIM_AB > LIM_C) ? LIM_AB : LIM_C;
    localparam int CNT_W      = $clog2(LIM_MAX + 1);
    localparam int QUAL_RAW   = (CYC_PER_MS * MR_MIN_US + 999) / 1000;
    localparam int QUAL_CYC   = (QUAL_RAW < 1) ? 1 : QUAL_RAW;

    logic mr_hold;
    logic tmr_run;
    logic tmr_done;

    srs_mr_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .QUAL_CYC    (QUAL_CYC)
    ) u_mr (
        .clk      (clk),
        .rst_n    (rst_n),
        .mr_async (mr_req),
        .mr_hold  (mr_hold)
    );

    srs_release_timer #(
        .CW    (CNT_W),
        .LIM_A (LIM_A),
        .LIM_B (LIM_B),
        .LIM_C (LIM_C)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .sel   (dly_sel),
        .done  (tmr_done)
    );

    srs_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .uv_low      (uv_low),
        .ov_high     (ov_high),
        .mr_hold     (mr_hold),
        .tmr_done    (tmr_done),
        .tmr_run     (tmr_run),
        .rst_out_n   (rst_out_n),
        .pad_pull_en (pad_pull_en)
    );
endmodule

// File: rtl/srs_checker.sv
module srs_checker (
    input logic clk,
    input logic rst_n,
    input logic uv_low,
    input logic mr_hold,
    input logic tmr_done,
    input logic rst_out_n
);
    a_r2_uv_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
        uv_low |=> !rst_out_n);

    a_r6_manual_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
        mr_hold |=> !rst_out_n);

    a_r4_release_after_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> $past(tmr_done));

    a_r9_uv_kills_count: assert property (@(posedge clk) disable iff (!rst_n)
        uv_low |=> !tmr_done);

    a_r8_manual_end_needs_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mr_hold) && !uv_low) |=> !rst_out_n);
endmodule

bind supply_reset_seq srs_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .uv_low    (uv_low),
    .mr_hold   (mr_hold),
    .tmr_done  (tmr_done),
    .rst_out_n (rst_out_n)
);

// File: tb/supply_reset_seq_tb_top.sv
`timescale 1ns/1ps
module supply_reset_seq_tb_top;
    localparam int CLK_HZ = 100_000; // delays 5000/10000/20000 cycles, Q = 2

    typedef struct packed {
        logic       uv;
        logic       ov;
        logic       mr;
        logic [1:0] sel;
        int         cyc;
        logic       exp;
        int         req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 2'd0, 5,    1'b0, 3},   // R3 low supply
        '{1'b0, 1'b0, 1'b0, 2'd0, 20,   1'b0, 3},   // R3 between levels, not confirmed
        '{1'b1, 1'b1, 1'b0, 2'd0, 20,   1'b0, 11},  // R11 both flags
        '{1'b0, 1'b1, 1'b0, 2'd0, 4990, 1'b0, 4},   // R4 before 5000
        '{1'b0, 1'b1, 1'b0, 2'd0, 20,   1'b1, 4},   // R4 after 5000
        '{1'b0, 1'b0, 1'b0, 2'd0, 10,   1'b1, 3},   // R3 hysteresis
        '{1'b0, 1'b0, 1'b1, 2'd0, 1,    1'b1, 7},   // R7 one-cycle pulse
        '{1'b0, 1'b0, 1'b0, 2'd0, 10,   1'b1, 7},   // R7 ignored
        '{1'b0, 1'b0, 1'b1, 2'd0, 2,    1'b1, 6},   // R6 Q-cycle pulse
        '{1'b0, 1'b0, 1'b0, 2'd0, 4,    1'b0, 6},   // R6 recognised
        '{1'b0, 1'b0, 1'b0, 2'd0, 4990, 1'b0, 8},   // R8 still delaying
        '{1'b0, 1'b0, 1'b0, 2'd0, 20,   1'b1, 8},   // R8 released
        '{1'b1, 1'b0, 1'b0, 2'd0, 1,    1'b0, 2}    // R2 one-cycle latency
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uv_low = 1'b0;
    logic       ov_high = 1'b0;
    logic       mr_req = 1'b0;
    logic [1:0] dly_sel = 2'd0;
    logic       rst_out_n;
    logic       pad_pull_en;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    supply_reset_seq #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .uv_low      (uv_low),
        .ov_high     (ov_high),
        .mr_req      (mr_req),
        .dly_sel     (dly_sel),
        .rst_out_n   (rst_out_n),
        .pad_pull_en (pad_pull_en)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // R10 checked on every call: pad_pull_en must be the inverse.
    task automatic check(input string tag, input logic exp);
        checks++;
        if (rst_out_n !== exp || pad_pull_en !== ~exp) begin
            failures++;
            $display("FAIL %s rst_out_n=%b pad_pull_en=%b expected %b/%b",
                     tag, rst_out_n, pad_pull_en, exp, ~exp);
        end
    endtask

    task automatic uv_pulse();
        uv_low = 1'b1;
        step(1);
        uv_low = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (190_000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        step(3);
        check("R1 during reset", 1'b0);
        rst_n = 1'b1;
        step(2);
        check("R1 after reset", 1'b0);

        for (int i = 0; i < NV; i++) begin
            uv_low  = VECS[i].uv;
            ov_high = VECS[i].ov;
            mr_req  = VECS[i].mr;
            dly_sel = VECS[i].sel;
            step(VECS[i].cyc);
            check($sformatf("R%0d row %0d", VECS[i].req, i), VECS[i].exp);
        end

        // R4 selection 01
        uv_low = 1'b0; ov_high = 1'b1; dly_sel = 2'd1;
        step(9990); check("R4 sel01 early", 1'b0);
        step(20);   check("R4 sel01 release", 1'b1);
        // R4 selection 10
        uv_pulse(); dly_sel = 2'd2;
        step(19990); check("R4 sel10 early", 1'b0);
        step(20);    check("R4 sel10 release", 1'b1);
        // R4 selection 11 behaves as 10
        uv_pulse(); dly_sel = 2'd3;
        step(19990); check("R4 sel11 early", 1'b0);
        step(20);    check("R4 sel11 release", 1'b1);

        // R5 selection change mid-count ignored
        uv_pulse(); dly_sel = 2'd0;
        step(100);  dly_sel = 2'd2;
        step(4890); check("R5 early", 1'b0);
        step(20);   check("R5 release on captured delay", 1'b1);

        // R9 undervoltage mid-count restarts the delay
        uv_pulse(); dly_sel = 2'd0;
        step(3000);
        uv_low = 1'b1; step(2); check("R2 mid-delay assert", 1'b0);
        uv_low = 1'b0;
        step(4990); check("R9 fresh delay early", 1'b0);
        step(20);   check("R9 fresh delay release", 1'b1);

        // R8 manual request again during delay restarts it
        mr_req = 1'b1; step(10); check("R6 manual held", 1'b0);
        mr_req = 1'b0; step(3000);
        mr_req = 1'b1; step(10);
        mr_req = 1'b0;
        step(4990); check("R8 restarted delay early", 1'b0);
        step(20);   check("R8 restarted delay release", 1'b1);

        // R1 logic reset while running
        rst_n = 1'b0; step(3);
        check("R1 reset mid-run", 1'b0);
        rst_n = 1'b1;
        step(4990); check("R1 delay after reset early", 1'b0);
        step(20);   check("R1 delay after reset release", 1'b1);

        finished = 1'b1;
        summary();
    end
endmodule